// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Aggregator

This block gathers single-cycle event pulses from a receiver datapath into a small number of interrupt channels, two by default. Every channel owns a group of source lines, a latched status register, a mask register and an output pin. A source pulse sets its status bit, and that bit stays set until the host reads it. The channel interrupt is the OR of every latched bit whose mask bit is clear. A set mask bit rejects its source for the interrupt, but the event is still recorded in status.

A host on a plain register port writes the masks and reads the status. A read of a channel's status returns the latched bits on the next cycle and clears them in the same edge. The channel's interrupt and pin drop as a result. After reset every mask bit is set, so nothing reaches an output until the host opens a mask. Each pin has an output-enable: when routing is off, the pin is released (enable low, data low). When routing is on, the pin drives the channel interrupt.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask bit reads 1, every status bit is 0, and `irq_o` and `pin_o` are all 0.
- R2: A 1 on a source line at a clock edge sets the matching status bit. The bit stays set, whatever the mask, until a read of that channel's status.
- R3: `irq_o[c]` is 1 exactly when some status bit of channel c has its mask bit at 0. A mask bit of 1 keeps its source out of the OR.
- R4: A read of a channel's status address loads the latched bits into `bus_rdata` on the next cycle and clears them at the same edge, so the interrupt falls in that cycle.
- R5: A source pulse that arrives at the same edge as a clearing read of its channel stays set after the read.
- R6: Clearing a mask bit whose status bit is still latched raises `irq_o` in the cycle after the mask write.
- R7: `pin_oe_o[c]` equals `route_en[c]`. When the enable is 1, `pin_o[c]` equals `irq_o[c]`. When it is 0, `pin_o[c]` is 0.
- R8: Writes to status addresses change no status bit. Mask registers read back the value last written.
- R9: A status read of one channel leaves the other channel's status and interrupt unchanged.
- R10: Address map, for the default of two channels: 0 = mask of channel 0, 1 = mask of channel 1, 2 = status of channel 0, 3 = status of channel 1. Mask bit i and status bit i belong to source line i of that channel. On `evt_i`, channel c occupies bits [c*8 +: 8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CH*SRC_W | Event pulses, channel c in bits [c*SRC_W +: SRC_W] |
| route_en | input | NUM_CH | Per-pin output routing enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | SRC_W | Write data |
| bus_rdata | output | SRC_W | Read data, valid the cycle after `bus_rd` |
| irq_o | output | NUM_CH | Channel interrupt flags |
| pin_o | output | NUM_CH | Pin data |
| pin_oe_o | output | NUM_CH | Pin output enable (0 = high impedance) |

## Verification
The hardest case to reach from the ports is an event that lands at the same edge as the read that clears its channel. Random traffic seldom produces that case with the source unmasked, so it would rarely show on `irq_o`. A directed sequence first opens a mask bit, then issues the status read together with a pulse on that very bit. It then checks both the returned data and the interrupt that stays high. Random cycles then mix sparse events, mask writes, ignored status writes and reads of both channels, all scored against a bench model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   typedef enum logic [0:0] {
      KIND_MASK   = 1'b0,
      KIND_STATUS = 1'b1
   } reg_kind_e;

   function automatic int unsigned addr_bits(input int unsigned n_ch);
      return (2 * n_ch <= 2) ? 1 : $clog2(2 * n_ch);
   endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask
);
   always_ff @(posedge clk) begin
      if (!rst_n)  mask <= '1;
      else if (we) mask <= wdata;
   end

   // R1: every source rejected right after reset
   p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask == '1));

   // R8: mask holds when not written
   p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mask));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr,
   output logic [W-1:0] status
);
   logic [W-1:0] kept;

   assign kept = clr ? '0 : status;

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= kept | evt;
   end

   // R2: latched bits survive without a clearing read
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((status & $past(status)) == $past(status)));

   // R5: a pulse is always captured, even during a clear
   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(evt)) == $past(evt)));

   // R4: a quiet clear empties the register
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (evt == '0)) |=> (status == '0));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
   parameter int unsigned W       = 8,
   parameter bit          PIN_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   input  logic [W-1:0] mask,
   input  logic         route_en,
   output logic         irq,
   output logic         pin,
   output logic         pin_oe
);
   logic [W-1:0] open_bits;

   assign open_bits = status & ~mask;
   assign irq       = |open_bits;

   generate
      if (PIN_REG) begin : g_pin_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pin    <= 1'b0;
               pin_oe <= 1'b0;
            end else begin
               pin    <= route_en & irq;
               pin_oe <= route_en;
            end
         end
      end else begin : g_pin_comb
         assign pin    = route_en & irq;
         assign pin_oe = route_en;

         // R7: a released pin never drives high
         p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_oe |-> !pin);
      end
   endgenerate

   // R3: a fully masked channel stays silent
   p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |-> !irq);

   // R3: an interrupt needs a latched source
   p_irq_has_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0));
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [NUM_CH-1:0] mask_we,
   output logic [NUM_CH-1:0] stat_clr,
   output reg_kind_e         sel_kind,
   output logic              sel_hit
);
   logic [NUM_CH-1:0] hit_mask;
   logic [NUM_CH-1:0] hit_stat;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign hit_mask[c] = (bus_addr == ADDR_W'(c));
      assign hit_stat[c] = (bus_addr == ADDR_W'(NUM_CH + c));
      assign mask_we[c]  = bus_wr & hit_mask[c];
      assign stat_clr[c] = bus_rd & hit_stat[c];
   end

   assign sel_kind = (|hit_stat) ? KIND_STATUS : KIND_MASK;
   assign sel_hit  = (|hit_mask) | (|hit_stat);

   // R10: one register selected at most
   always_comb begin
      a_one_sel_r10: assert ($onehot0({hit_mask, hit_stat}));
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned SRC_W   = 8,
   parameter int unsigned NUM_CH  = 2,
   parameter bit          PIN_REG = 1'b0,
   localparam int unsigned ADDR_W = addr_bits(NUM_CH),
   localparam int unsigned EVT_W  = NUM_CH * SRC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic [NUM_CH-1:0] route_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [SRC_W-1:0]  bus_wdata,
   output logic [SRC_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] irq_o,
   output logic [NUM_CH-1:0] pin_o,
   output logic [NUM_CH-1:0] pin_oe_o
);
   if (SRC_W < 1 || SRC_W > 32) begin : g_bad_width
      $error("irq_aggregator: SRC_W must lie in 1..32");
   end
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_count
      $error("irq_aggregator: NUM_CH must lie in 1..16");
   end

   logic [NUM_CH-1:0]            mask_we;
   logic [NUM_CH-1:0]            stat_clr;
   reg_kind_e                    sel_kind;
   logic                         sel_hit;
   logic [NUM_CH-1:0][SRC_W-1:0] mask_q;
   logic [NUM_CH-1:0][SRC_W-1:0] stat_q;
   logic [SRC_W-1:0]             rd_mux;

   irq_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .mask_we  (mask_we),
      .stat_clr (stat_clr),
      .sel_kind (sel_kind),
      .sel_hit  (sel_hit)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      irq_mask_reg #(.W(SRC_W)) u_mask (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (mask_we[c]),
         .wdata (bus_wdata),
         .mask  (mask_q[c])
      );

      irq_status_reg #(.W(SRC_W)) u_stat (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (evt_i[c*SRC_W +: SRC_W]),
         .clr    (stat_clr[c]),
         .status (stat_q[c])
      );

      irq_gate #(.W(SRC_W), .PIN_REG(PIN_REG)) u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .status   (stat_q[c]),
         .mask     (mask_q[c]),
         .route_en (route_en[c]),
         .irq      (irq_o[c]),
         .pin      (pin_o[c]),
         .pin_oe   (pin_oe_o[c])
      );

      // R8: a status write leaves the latched bits alone
      p_stat_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && !bus_rd && (bus_addr == ADDR_W'(NUM_CH + c))
          && (evt_i[c*SRC_W +: SRC_W] == '0))
         |=> (stat_q[c] == $past(stat_q[c])));

      // R9: reads elsewhere never clear this channel
      p_ch_indep_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_clr[c] && irq_o[c] && !mask_we[c]) |=> irq_o[c]);
   end

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (sel_hit && sel_kind == KIND_MASK   && bus_addr == ADDR_W'(c))
            rd_mux = mask_q[c];
         if (sel_hit && sel_kind == KIND_STATUS && bus_addr == ADDR_W'(NUM_CH + c))
            rd_mux = stat_q[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/100ps
module irq_aggregator_test;
   localparam int W = 8;
   localparam int N = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N*W-1:0] evt_i = '0;
   logic [N-1:0]   route_en = '0;
   logic           bus_wr = 1'b0;
   logic           bus_rd = 1'b0;
   logic [1:0]     bus_addr = '0;
   logic [W-1:0]   bus_wdata = '0;
   logic [W-1:0]   bus_rdata;
   logic [N-1:0]   irq_o, pin_o, pin_oe_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [W-1:0] st [N];
   logic [W-1:0] mk [N];

   irq_aggregator uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .route_en(route_en),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
   );

   always #2 clk = ~clk;

   function automatic logic exp_irq(input int c);
      return |(st[c] & ~mk[c]);
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
      end
   endtask

   // one clock: drive at negedge, model the edge, check 1 ns after it
   task automatic step(input string tag, input logic [W-1:0] e0, input logic [W-1:0] e1,
                       input logic wr, input logic rd, input logic [1:0] addr,
                       input logic [W-1:0] wd, input logic [N-1:0] route);
      logic [W-1:0] exp_rd;
      logic [W-1:0] ev [N];
      @(negedge clk);
      evt_i = {e1, e0}; bus_wr = wr; bus_rd = rd; bus_addr = addr;
      bus_wdata = wd; route_en = route;
      ev[0] = e0; ev[1] = e1;
      exp_rd = (addr < 2) ? mk[addr] : st[addr-2];
      for (int c = 0; c < N; c++) begin
         if (rd && addr == 2'(c + 2)) st[c] = ev[c];
         else                         st[c] = st[c] | ev[c];
         if (wr && addr == 2'(c))     mk[c] = wd;
      end
      @(posedge clk);
      #1;
      for (int c = 0; c < N; c++) begin
         chk(tag, $sformatf("irq%0d", c), 32'(irq_o[c]), 32'(exp_irq(c)));
         chk("R7", $sformatf("oe%0d", c), 32'(pin_oe_o[c]), 32'(route[c]));
         chk("R7", $sformatf("pin%0d", c), 32'(pin_o[c]), 32'(route[c] & exp_irq(c)));
      end
      if (rd) chk(tag, "rdata", 32'(bus_rdata), 32'(exp_rd));
   endtask

   task automatic idle(input string tag);
      step(tag, '0, '0, 1'b0, 1'b0, 2'd0, '0, route_en);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7151));
      for (int c = 0; c < N; c++) begin st[c] = '0; mk[c] = '1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R1: reset state at the ports
      chk("R1", "irq", 32'(irq_o), 32'h0);
      chk("R1", "pin", 32'(pin_o), 32'h0);
      // R1 R10: masks read all ones, status zero
      step("R1", '0, '0, 0, 1, 2'd0, '0, 2'b11);
      step("R10", '0, '0, 0, 1, 2'd1, '0, 2'b11);
      step("R1", '0, '0, 0, 1, 2'd2, '0, 2'b11);
      // R3: masked event latches but stays silent; R2 read shows it
      step("R3", 8'h08, '0, 0, 0, 2'd0, '0, 2'b11);
      idle("R2");
      step("R2", '0, '0, 0, 1, 2'd2, '0, 2'b11);
      // R6: latch again, then unmask -> irq next cycle
      step("R2", 8'h08, '0, 0, 0, 2'd0, '0, 2'b11);
      step("R6", '0, '0, 1, 0, 2'd0, 8'hF7, 2'b11);
      step("R8", '0, '0, 0, 1, 2'd0, '0, 2'b11);
      // R8: status write ignored
      step("R8", '0, '0, 1, 0, 2'd2, 8'h00, 2'b11);
      // R9: channel 1 event, read channel 1, channel 0 stays
      step("R9", '0, 8'h01, 1, 0, 2'd1, 8'hFE, 2'b10);
      step("R9", '0, '0, 0, 1, 2'd3, '0, 2'b10);
      // R5: read channel 0 while its open bit pulses again
      step("R5", 8'h08, '0, 0, 1, 2'd2, '0, 2'b01);
      idle("R5");
      // R4: quiet read clears and drops irq
      step("R4", '0, '0, 0, 1, 2'd2, '0, 2'b01);
      step("R7", 8'h08, 8'h01, 0, 0, 2'd0, '0, 2'b00);
      step("R7", '0, '0, 0, 0, 2'd0, '0, 2'b01);
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] r0, r1;
         int op;
         r0 = ($urandom % 4 == 0) ? W'($urandom) & W'($urandom) : '0;
         r1 = ($urandom % 4 == 0) ? W'($urandom) & W'($urandom) : '0;
         op = $urandom % 6;
         step("R3", r0, r1, op == 0 || op == 2, op == 1 || op == 3,
              (op == 2) ? 2'(2 + $urandom % 2) : 2'($urandom % 4),
              W'($urandom), 2'($urandom));
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule